// File: doc/BRIEF.md
# Crash Code Encoder for a Maintenance Panel

This block watches the error flags of a microcoded processor and reduces them to a single decimal crash number for a maintenance panel. It looks at register-file and control-store parity, stack overflow or underflow, and several memory-controller fault flavours. It also looks at an internal-path parity fault, a map-out-of-bounds fault, a fault that follows a page-load instruction, and a breakpoint request. For several of these faults it adds the number of the task that failed, so an operator can read that task straight off the panel.

Parity and stack errors form one group. That group adds binary weights to a base of 120. Every other fault has its own base, and most of these bases sit 20 apart. The first error seen after reset or after a clear is captured. Its code is held, with a valid strobe high, until a synchronous clear or reset. Errors that arrive while a code is held are ignored.

Top module: `panel_crash_encoder`

## Requirements
- R1: During and right after reset, `code_valid` is 0 and `code` is 0.
- R2: When any of `mc_err`, `rf_par_err`, `cs_par_err` or `stk_err` is high, the code is 120 + 1·mc_err + 2·rf_par_err + 4·cs_par_err + 8·stk_err.
- R3: When several causes are present in one cycle, the code follows this priority, highest first:
  - the parity/stack group (R2)
  - two double-bit errors (R4)
  - a double-bit error (R5)
  - an init page fault (R6)
  - an error with no pipe record (R7)
  - an internal-path parity fault (R8)
  - map out of bounds (R9)
  - a page-load fault (R10)
  - a breakpoint (R11)
- R4: With `dbl_bit_twice` high as the top cause, the code is 117.
- R5: With `dbl_bit_err` high as the top cause, the code is 200 + `pipe_task`.
- R6: With `init_pg_fault` high as the top cause, the code is 220 + `pipe_task`.
- R7: With `no_pipe_rec` high as the top cause, the code is 136.
- R8: With `hw_par_fault` high as the top cause, the code is 160 + `cur_task`.
- R9: With `map_oob_err` high as the top cause, the code is 140 + `cur_task`.
- R10: With `pgload_fault` high as the top cause, the code is 180 + `cur_task`.
- R11: With `brk_req` high as the top cause, the code is 240 + `cur_task`.
- R12: An error sampled at a rising edge while `code_valid` is 0 and `clr` is 0 sets `code_valid` and `code` at that edge. With no error present, `code_valid` stays 0.
- R13: While `code_valid` is 1 and `clr` is 0, `code` and `code_valid` do not change, whatever errors arrive.
- R14: `clr` high at a rising edge returns `code` to 0 and `code_valid` to 0, even if errors are present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the held code |
| mc_err | input | 1 | Memory-controller error, weight 1 |
| rf_par_err | input | 1 | Register-file parity error, weight 2 |
| cs_par_err | input | 1 | Control-store parity error, weight 4 |
| stk_err | input | 1 | Stack overflow or underflow, weight 8 |
| dbl_bit_twice | input | 1 | Two double-bit memory errors |
| dbl_bit_err | input | 1 | Double-bit memory error |
| init_pg_fault | input | 1 | Page or write-protect fault during init |
| no_pipe_rec | input | 1 | Error indication with nothing recorded in the pipe |
| hw_par_fault | input | 1 | Internal-path parity fault |
| map_oob_err | input | 1 | Map out of bounds during init |
| pgload_fault | input | 1 | Fault after a page-load instruction |
| brk_req | input | 1 | Breakpoint or set-fault request |
| cur_task | input | 4 | Current task number |
| pipe_task | input | 4 | Task number recorded in the pipe |
| code | output | 10 | Held crash code, binary |
| code_valid | output | 1 | A code is held |

## Verification
The embedded properties check the following on every cycle:
- exactly one cause is granted whenever any cause is present;
- the group code stays inside its 120–135 band;
- a valid code never leaves the 117–255 span;
- the capture, hold and clear behaviour of the strobe and the code.

The exact arithmetic of each band is shown only by the bench's scenarios. The same holds for which task number is added and for how simultaneous causes rank. The bench sweeps every combination of the twelve fault flags, with varying task numbers. After each capture it applies conflicting errors and a clear that collides with errors.

// File: rtl/crash_enc_pkg.sv
// Package: shared constants and cause encoding for the crash code encoder.
// Assumes codes fit in CODE_W_DEF bits (largest code is 255).
package crash_enc_pkg;
    localparam int TASK_W_DEF = 4;
    localparam int CODE_W_DEF = 10;
    localparam int GROUP_W    = 4;

    // Cause indices, lowest index is highest priority.
    localparam int C_GROUP  = 0;
    localparam int C_DUAL   = 1;
    localparam int C_DBL    = 2;
    localparam int C_INITPF = 3;
    localparam int C_NOREC  = 4;
    localparam int C_HWPAR  = 5;
    localparam int C_OOB    = 6;
    localparam int C_PGLD   = 7;
    localparam int C_BRK    = 8;
    localparam int NUM_CAUSE = 9;

    typedef enum logic [1:0] {
        ADD_NONE  = 2'd0,
        ADD_GROUP = 2'd1,
        ADD_PIPE  = 2'd2,
        ADD_CUR   = 2'd3
    } add_kind_e;

    // Base value of each cause band.
    function automatic int cause_base(input int idx);
        case (idx)
            C_GROUP:  return 120;
            C_DUAL:   return 117;
            C_DBL:    return 200;
            C_INITPF: return 220;
            C_NOREC:  return 136;
            C_HWPAR:  return 160;
            C_OOB:    return 140;
            C_PGLD:   return 180;
            default:  return 240;
        endcase
    endfunction

    // What gets added to the base for each cause.
    function automatic add_kind_e cause_add(input int idx);
        case (idx)
            C_GROUP:           return ADD_GROUP;
            C_DUAL, C_NOREC:   return ADD_NONE;
            C_DBL, C_INITPF:   return ADD_PIPE;
            default:           return ADD_CUR;
        endcase
    endfunction
endpackage

// File: rtl/crash_cause_arbiter.sv
// Fixed-priority arbiter: grants the lowest-index active request.
// Assumes index 0 is the highest priority; output is one-hot or zero.
module crash_cause_arbiter #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any_req
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    // Priority chain: each stage passes on whether a higher request exists.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]     = req[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | req[g];
    end

    assign any_req = blocked[N];

    // R3: one cause granted exactly when some cause is requested
    p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ($countones(grant) == 1));

    // R3: a grant only goes to an active request
    p_grant_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~req) == '0));
endmodule

// File: rtl/crash_code_calc.sv
// Code arithmetic: base of the granted cause plus its offset.
// Assumes grant is one-hot or zero; zero grant yields code 0.
module crash_code_calc
    import crash_enc_pkg::*;
#(
    parameter int N      = NUM_CAUSE,
    parameter int TASK_W = TASK_W_DEF,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       grant,
    input  logic [GROUP_W-1:0] group_flags,
    input  logic [TASK_W-1:0]  cur_task,
    input  logic [TASK_W-1:0]  pipe_task,
    output logic [CODE_W-1:0]  code
);
    // Group flags are binary-weighted, so the vector itself is the sum.
    logic [CODE_W-1:0] group_sum;
    assign group_sum = CODE_W'(group_flags);

    // Combine base and offset of the granted cause.
    always_comb begin
        code = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) begin
                case (cause_add(k))
                    ADD_GROUP: code = CODE_W'(cause_base(k)) + group_sum;
                    ADD_PIPE:  code = CODE_W'(cause_base(k)) + CODE_W'(pipe_task);
                    ADD_CUR:   code = CODE_W'(cause_base(k)) + CODE_W'(cur_task);
                    default:   code = CODE_W'(cause_base(k));
                endcase
            end
        end
    end

    // R2: a group grant stays within its 120..135 band
    p_group_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant[C_GROUP] |-> (code >= CODE_W'(120) && code <= CODE_W'(135)));
endmodule

// File: rtl/crash_code_hold.sv
// Capture register: latches the first code and holds it until clear.
// Assumes clr and rst_n are synchronous; clr wins over a new error.
module crash_code_hold #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              any_err,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              valid_q
);
    // Capture on first error, hold otherwise, zero on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else if (!valid_q && any_err) begin
            code_q  <= code_in;
            valid_q <= 1'b1;
        end
    end

    // R12: first error is captured at the next edge
    p_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && any_err && !clr) |=> valid_q);

    // R12: no error keeps the strobe low
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && !any_err) |=> !valid_q);

    // R13: held code is stable until a clear
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !clr) |=> (valid_q && $stable(code_q)));

    // R14: clear empties the register
    p_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!valid_q && code_q == '0));
endmodule

// File: rtl/panel_crash_encoder.sv
// Top: maps fault flags to causes, picks the highest-priority one,
// computes the panel code and holds the first code seen.
// Assumes all inputs are synchronous to clk.
module panel_crash_encoder
    import crash_enc_pkg::*;
#(
    parameter int TASK_W = TASK_W_DEF,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mc_err,
    input  logic              rf_par_err,
    input  logic              cs_par_err,
    input  logic              stk_err,
    input  logic              dbl_bit_twice,
    input  logic              dbl_bit_err,
    input  logic              init_pg_fault,
    input  logic              no_pipe_rec,
    input  logic              hw_par_fault,
    input  logic              map_oob_err,
    input  logic              pgload_fault,
    input  logic              brk_req,
    input  logic [TASK_W-1:0] cur_task,
    input  logic [TASK_W-1:0] pipe_task,
    output logic [CODE_W-1:0] code,
    output logic              code_valid
);
    localparam int N = NUM_CAUSE;

    logic [GROUP_W-1:0] group_flags;
    logic [N-1:0]       req;
    logic [N-1:0]       grant;
    logic               any_req;
    logic [CODE_W-1:0]  code_next;

    assign group_flags = {stk_err, cs_par_err, rf_par_err, mc_err};

    // Build the request vector in priority order.
    always_comb begin
        req           = '0;
        req[C_GROUP]  = |group_flags;
        req[C_DUAL]   = dbl_bit_twice;
        req[C_DBL]    = dbl_bit_err;
        req[C_INITPF] = init_pg_fault;
        req[C_NOREC]  = no_pipe_rec;
        req[C_HWPAR]  = hw_par_fault;
        req[C_OOB]    = map_oob_err;
        req[C_PGLD]   = pgload_fault;
        req[C_BRK]    = brk_req;
    end

    crash_cause_arbiter #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .grant   (grant),
        .any_req (any_req)
    );

    crash_code_calc #(.N(N), .TASK_W(TASK_W), .CODE_W(CODE_W)) u_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (grant),
        .group_flags (group_flags),
        .cur_task    (cur_task),
        .pipe_task   (pipe_task),
        .code        (code_next)
    );

    crash_code_hold #(.CODE_W(CODE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .any_err (any_req),
        .code_in (code_next),
        .code_q  (code),
        .valid_q (code_valid)
    );

    // R1: strobe low in the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!code_valid && code == '0));

    // R12: any held code lies in the defined span
    p_code_span_r12: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (code >= CODE_W'(117) && code <= CODE_W'(255)));
endmodule

// File: tb/panel_crash_encoder_tb.sv
module panel_crash_encoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [11:0] flags = '0;
    logic [3:0] cur_task = '0;
    logic [3:0] pipe_task = '0;
    logic [9:0] code;
    logic code_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Flag bit map: [0]mc [1]rf [2]cs [3]stk [4]dual [5]dbl [6]initpf
    // [7]norec [8]hwpar [9]oob [10]pgld [11]brk
    panel_crash_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .mc_err(flags[0]), .rf_par_err(flags[1]), .cs_par_err(flags[2]),
        .stk_err(flags[3]), .dbl_bit_twice(flags[4]), .dbl_bit_err(flags[5]),
        .init_pg_fault(flags[6]), .no_pipe_rec(flags[7]),
        .hw_par_fault(flags[8]), .map_oob_err(flags[9]),
        .pgload_fault(flags[10]), .brk_req(flags[11]),
        .cur_task(cur_task), .pipe_task(pipe_task),
        .code(code), .code_valid(code_valid)
    );

    function automatic int exp_code(input logic [11:0] f, input int cur, input int pipe);
        if (|f[3:0]) return 120 + int'(f[3:0]);
        if (f[4])  return 117;
        if (f[5])  return 200 + pipe;
        if (f[6])  return 220 + pipe;
        if (f[7])  return 136;
        if (f[8])  return 160 + cur;
        if (f[9])  return 140 + cur;
        if (f[10]) return 180 + cur;
        if (f[11]) return 240 + cur;
        return 0;
    endfunction

    function automatic string exp_tag(input logic [11:0] f);
        int n;
        n = $countones(f[11:4]) + ((|f[3:0]) ? 1 : 0);
        if (n > 1)   return "R3";
        if (|f[3:0]) return "R2";
        if (f[4])  return "R4";
        if (f[5])  return "R5";
        if (f[6])  return "R6";
        if (f[7])  return "R7";
        if (f[8])  return "R8";
        if (f[9])  return "R9";
        if (f[10]) return "R10";
        if (f[11]) return "R11";
        return "R12";
    endfunction

    task automatic check(input string req, input int act_c, input int exp_c,
                         input bit act_v, input bit exp_v);
        checks++;
        if (act_c != exp_c || act_v != exp_v) begin
            errors++;
            $display("FAIL %s code=%0d valid=%0d expected code=%0d valid=%0d",
                     req, act_c, act_v, exp_c, exp_v);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(code), 0, code_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(code), 0, code_valid, 1'b0);

        for (int i = 0; i < 4096; i++) begin
            // Capture: R2..R12
            flags     = 12'(i);
            cur_task  = 4'((i * 5) % 16);
            pipe_task = 4'((i * 11 + 3) % 16);
            e = exp_code(flags, int'(cur_task), int'(pipe_task));
            @(negedge clk);
            check(exp_tag(flags), int'(code), e, code_valid, (i != 0));
            // R13: conflicting errors while held are ignored
            flags     = ~12'(i);
            cur_task  = ~cur_task;
            pipe_task = ~pipe_task;
            if (i != 0) begin
                @(negedge clk);
                check("R13", int'(code), e, code_valid, 1'b1);
            end
            // R14: clear wins over errors present in the same cycle
            flags = 12'hFFF;
            clr   = 1'b1;
            @(negedge clk);
            check("R14", int'(code), 0, code_valid, 1'b0);
            clr   = 1'b0;
            flags = '0;
            @(negedge clk);
            check("R12", int'(code), 0, code_valid, 1'b0);
        end

        // R1: reset also empties a held code
        flags = 12'h800;
        @(negedge clk);
        flags = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(code), 0, code_valid, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule